// File: doc/BRIEF.md
# Serial Flash Single-Lane Read Front-End

This block is the device-side command front-end of a serial NOR flash, serving read traffic on a single data lane at single data rate. A host selects the device with an active-low select, toggles a serial clock that idles low, and shifts an 8-bit opcode and then an address in on the input line. The block then waits out any configured dummy cycles and streams bytes from an auto-incrementing address back on the output line until the host deselects it.

The serial clock is oversampled by the block's own clock, so each half period of the serial clock must last at least two system clock cycles. The opcode picks the address width, either alone or together with the extended-address bit held in an 8-bit bank register. For 3-byte commands with extended addressing off, the bank register supplies the upper address byte. The flash array is modelled by a small synchronous RAM. It decodes only address bits [30:29] as the upper index bits and address bits [3:0] as the lower ones, so the RAM index is `{addr[30:29], addr[3:0]}`.

The RAM is filled through a valid/ready load port. `ld_ready` is high exactly while the device is deselected (`cs_n` high). A byte is written in any system cycle where `ld_valid` and `ld_ready` are both high. While `ld_ready` is low the host holds the request or withdraws it, and a withdrawn request writes nothing.

Top module: `spi_read_frontend`

## Requirements
- R1: While `cs_n` is low, opcode, address, dummy and bank bits are taken from `si` on each rising `sck` edge, most significant bit first. During data output, `so` changes only after a falling `sck` edge and gives each byte most significant bit first. `so_oe` rises with the first data bit.
- R2: Opcode 03h with the bank register's bit 7 at 0 takes 3 address bytes. The start address is `{1'b0, bank[6:0], a[23:0]}`, and data starts on the first falling edge after the last address bit.
- R3: Opcodes 03h and 0Bh with bank bit 7 at 1 take a 4-byte address, which is used unchanged.
- R4: Opcodes 13h and 0Ch always take a 4-byte address, whatever the value of bank bit 7.
- R5: Opcode 17h loads the next 8 input bits into the bank register and needs no write enable. Reset clears the register, so the extended-address bit starts at 0.
- R6: Fast reads (0Bh with the same address width as 03h, and 0Ch) insert a number of dummy `sck` cycles set by `lat_code`: 8 for codes 0, 1 and 2, and 0 for code 3. Opcodes 03h and 13h insert none.
- R7: After each byte the 32-bit address increments, wrapping from FFFFFFFFh to 0, so a read streams for as long as `cs_n` stays low.
- R8: When a read opcode is decoded while `busy` is high, the read is ignored and `so_oe` stays low until deselect.
- R9: Raising `cs_n` aborts any phase, and the next selection starts a new opcode. An opcode other than 03h, 0Bh, 0Ch, 13h and 17h is ignored until deselect and leaves the bank register unchanged.
- R10: `ld_ready` equals `cs_n`. A load attempted while `cs_n` is low, and withdrawn before deselect, leaves the RAM unchanged.
- R11: After reset, or one system cycle after `cs_n` goes high, `so_oe` is 0. During reset `ld_ready` follows the high `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so` |
| busy | input | 1 | High while a program or erase is running |
| lat_code | input | 2 | Latency code for fast reads |
| ld_valid | input | 1 | RAM load request |
| ld_ready | output | 1 | RAM load can be accepted |
| ld_idx | input | HI_W+LO_W | RAM index to load |
| ld_data | input | 8 | Byte to load |

## Verification
On every cycle, assertions check the following:
- `so` holds except after a detected falling edge.
- The bank register changes only when a bank write completes.
- The address steps by one after each streamed byte.
- A read opcode decoded while busy never reaches the address phase.
- Output enable drops one cycle after deselect.

Only the bench's scenarios can show the following:
- The assembled start address for each opcode and extended-bit combination.
- The dummy-cycle counts for each latency code.
- Streaming across the RAM's low-index alias and across the 32-bit wrap.
- Ignored opcodes.
- Aborted commands.
- A refused load that leaves the RAM unchanged.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_BANK,
    ST_SKIP
  } srf_state_e;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_READ4  = 8'h13;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam logic [7:0] OP_FAST4  = 8'h0C;
  localparam logic [7:0] OP_BANKWR = 8'h17;

  function automatic logic [3:0] dummy_cycles(input logic [1:0] code);
    return (code == 2'b11) ? 4'd0 : 4'd8;
  endfunction
endpackage

// File: rtl/srf_edge_detect.sv
module srf_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  output logic rise,
  output logic fall
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign rise = !cs_n && sck && !sck_q;
  assign fall = !cs_n && !sck && sck_q;
endmodule

// File: rtl/srf_array.sv
module srf_array #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/srf_cmd_fsm.sv
module srf_cmd_fsm
  import srf_pkg::*;
#(
  parameter int LO_W   = 4,
  parameter int HI_W   = 2,
  parameter int HI_LSB = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 si,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 busy,
  input  logic [1:0]           lat_code,
  input  logic [7:0]           rd_data,
  output logic [HI_W+LO_W-1:0] mem_idx,
  output logic                 so,
  output logic                 so_oe
);
  srf_state_e        state;
  logic [5:0]        cnt;
  logic [7:0]        sh;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        bank;
  logic              wide;
  logic              fast;
  logic [2:0]        bitidx;
  logic [3:0]        dum_last;

  // decode of the byte completing on this rising edge
  logic [7:0]        opc_now;
  logic              is_rd3, is_rd4, is_read, fast_now, wide_now;
  logic [ADDR_W-1:0] addr_shift, addr_full;
  logic [5:0]        last_bit;
  logic [3:0]        ndum;
  logic              bank_we;

  always_comb begin
    opc_now    = {sh[6:0], si};
    is_rd3     = (opc_now == OP_READ)  || (opc_now == OP_FAST);
    is_rd4     = (opc_now == OP_READ4) || (opc_now == OP_FAST4);
    is_read    = is_rd3 || is_rd4;
    fast_now   = (opc_now == OP_FAST)  || (opc_now == OP_FAST4);
    wide_now   = is_rd4 || (is_rd3 && bank[7]);
    addr_shift = {addr[ADDR_W-2:0], si};
    addr_full  = wide ? addr_shift : {1'b0, bank[6:0], addr_shift[23:0]};
    last_bit   = wide ? 6'd31 : 6'd23;
    ndum       = dummy_cycles(lat_code);
    bank_we    = rise && (state == ST_BANK) && (cnt == 6'd7);
  end

  assign mem_idx = {addr[HI_LSB +: HI_W], addr[LO_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_CMD;
      cnt      <= '0;
      sh       <= '0;
      addr     <= '0;
      bank     <= '0;
      wide     <= 1'b0;
      fast     <= 1'b0;
      bitidx   <= 3'd7;
      dum_last <= '0;
      so       <= 1'b0;
      so_oe    <= 1'b0;
    end else if (cs_n) begin
      state <= ST_CMD;
      cnt   <= '0;
      so_oe <= 1'b0;
    end else begin
      if (rise) begin
        case (state)
          ST_CMD: begin
            sh  <= opc_now;
            cnt <= cnt + 6'd1;
            if (cnt == 6'd7) begin
              cnt <= '0;
              if (is_read && !busy) begin
                state <= ST_ADDR;
                addr  <= '0;
                wide  <= wide_now;
                fast  <= fast_now;
              end else if (opc_now == OP_BANKWR) begin
                state <= ST_BANK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR: begin
            addr <= addr_shift;
            cnt  <= cnt + 6'd1;
            if (cnt == last_bit) begin
              cnt      <= '0;
              addr     <= addr_full;
              bitidx   <= 3'd7;
              dum_last <= ndum - 4'd1;
              state    <= (fast && ndum != 4'd0) ? ST_DUMMY : ST_DATA;
            end
          end
          ST_DUMMY: begin
            cnt <= cnt + 6'd1;
            if (cnt[3:0] == dum_last) begin
              cnt   <= '0;
              state <= ST_DATA;
            end
          end
          ST_BANK: begin
            sh  <= opc_now;
            cnt <= cnt + 6'd1;
            if (cnt == 6'd7) begin
              bank  <= opc_now;
              state <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
      if (fall && state == ST_DATA) begin
        so     <= rd_data[bitidx];
        so_oe  <= 1'b1;
        bitidx <= bitidx - 3'd1;
        if (bitidx == 3'd0) addr <= addr + 32'd1;
      end
    end
  end

  // R1: output bit only moves after a falling edge
  p_so_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(so));

  // R5: bank register changes only on a completed bank write
  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank));

  // R7: address steps by one after each streamed byte
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && state == ST_DATA && bitidx == 3'd0) |=> (addr == $past(addr) + 32'd1));

  // R8: read decoded while busy never enters the address phase
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && state == ST_CMD && cnt == 6'd7 && busy) |=> (state != ST_ADDR));
endmodule

// File: rtl/spi_read_frontend.sv
module spi_read_frontend #(
  parameter int LO_W   = 4,
  parameter int HI_W   = 2,
  parameter int HI_LSB = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 si,
  output logic                 so,
  output logic                 so_oe,
  input  logic                 busy,
  input  logic [1:0]           lat_code,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [HI_W+LO_W-1:0] ld_idx,
  input  logic [7:0]           ld_data
);
  localparam int IDX_W = HI_W + LO_W;

  logic             rise, fall;
  logic [IDX_W-1:0] mem_idx;
  logic [7:0]       rd_data;
  logic             ld_we;

  assign ld_ready = cs_n;
  assign ld_we    = ld_valid && ld_ready;

  srf_edge_detect u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .sck  (sck),
    .rise (rise),
    .fall (fall)
  );

  srf_array #(.IDX_W(IDX_W)) u_array (
    .clk    (clk),
    .we     (ld_we),
    .wr_idx (ld_idx),
    .wr_data(ld_data),
    .rd_idx (mem_idx),
    .rd_data(rd_data)
  );

  srf_cmd_fsm #(.LO_W(LO_W), .HI_W(HI_W), .HI_LSB(HI_LSB)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .si      (si),
    .rise    (rise),
    .fall    (fall),
    .busy    (busy),
    .lat_code(lat_code),
    .rd_data (rd_data),
    .mem_idx (mem_idx),
    .so      (so),
    .so_oe   (so_oe)
  );

  // R11: deselect turns the output driver off on the next cycle
  p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe);
endmodule

// File: tb/spi_read_frontend_tb.sv
`timescale 1ns/1ps
module spi_read_frontend_tb;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck, si, busy, ld_valid;
  logic [1:0] lat_code;
  logic [5:0] ld_idx;
  logic [7:0] ld_data;
  logic       so, so_oe, ld_ready;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  done = 1'b0;
  logic [7:0] bank_model = 8'h00;

  always #4 clk = ~clk;

  spi_read_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .busy(busy), .lat_code(lat_code),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_idx(ld_idx), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic int idx_of(input logic [31:0] a);
    return int'({a[30:29], a[3:0]});
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      si = v[i]; sck = 1'b0; tick(4);
      sck = 1'b1; tick(4);
    end
  endtask

  task automatic read_byte(output logic [7:0] v, output bit oe_all, output bit oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; tick(4);
      v[i] = so;
      oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1; tick(4);
    end
  endtask

  task automatic select();
    cs_n = 1'b0; sck = 1'b0; tick(2);
  endtask

  task automatic deselect();
    sck = 1'b0; tick(2); cs_n = 1'b1; tick(4);
  endtask

  task automatic set_bank(input logic [7:0] v);
    select(); send_byte(8'h17); send_byte(v); deselect();
    bank_model = v;
  endtask

  task automatic run_read(input logic [7:0] op, input logic [31:0] a, input int nb, input string req);
    bit four, fast, oe_all, oe_any, oe_ok;
    int ndum;
    logic [31:0] start;
    logic [7:0] v;
    four  = (op == 8'h13 || op == 8'h0C) || ((op == 8'h03 || op == 8'h0B) && bank_model[7]);
    fast  = (op == 8'h0B || op == 8'h0C);
    start = four ? a : {1'b0, bank_model[6:0], a[23:0]};
    ndum  = (fast && lat_code != 2'b11) ? 8 : 0;
    oe_ok = 1'b1;
    select();
    send_byte(op);
    if (four) send_byte(a[31:24]);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    for (int d = 0; d < ndum; d++) begin
      si = 1'b0; sck = 1'b0; tick(4); sck = 1'b1; tick(4);
    end
    for (int k = 0; k < nb; k++) begin
      logic [31:0] ak;
      ak = start + 32'(k);
      read_byte(v, oe_all, oe_any);
      oe_ok &= oe_all;
      check(v == pat(idx_of(ak)), (k == 0) ? req : {req, " R7 stream"}, {24'h0, v}, {24'h0, pat(idx_of(ak))});
    end
    check(oe_ok, {req, " R1 so_oe during data"}, {31'h0, oe_ok}, 32'h1);
    deselect();
    check(so_oe == 1'b0, "R11 so_oe off after deselect", {31'h0, so_oe}, 32'h0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [4];
    logic [7:0] v;
    bit oe_all, oe_any;
    ops[0] = 8'h03; ops[1] = 8'h13; ops[2] = 8'h0B; ops[3] = 8'h0C;

    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; busy = 1'b0;
    lat_code = 2'b00; ld_valid = 1'b0; ld_idx = '0; ld_data = '0;
    tick(5);
    check(so_oe == 1'b0, "R11 reset so_oe", {31'h0, so_oe}, 32'h0);
    check(ld_ready == 1'b1, "R11 reset ld_ready", {31'h0, ld_ready}, 32'h1);
    rst_n = 1'b1; tick(2);

    // fill the RAM through the load port (R10)
    for (int i = 0; i < 64; i++) begin
      ld_valid = 1'b1; ld_idx = 6'(i); ld_data = pat(i);
      tick(1);
    end
    ld_valid = 1'b0; tick(2);

    // R5: after reset the extended bit is 0, so 03h takes 3 bytes with bank 0
    run_read(8'h03, 32'hC012_345E, 3, "R5 R2 reset bank 3-byte");

    // sweep: extended bit x opcode x latency code x address
    for (int ext = 0; ext < 2; ext++) begin
      for (int oi = 0; oi < 4; oi++) begin
        for (int lc = 0; lc < 4; lc++) begin
          for (int ai = 0; ai < 2; ai++) begin
            logic [31:0] a;
            string req;
            a = (ai == 0) ? 32'hC0A5_5A0E : 32'h3F12_340F;
            set_bank({ext[0], (ai == 0) ? 7'h2B : 7'h55});
            lat_code = 2'(lc);
            if (oi >= 2)          req = "R6 fast read";
            else if (oi == 1)     req = "R4 4-byte opcode";
            else if (ext == 1)    req = "R3 extended 4-byte";
            else                  req = "R2 banked 3-byte";
            run_read(ops[oi], a, 3, req);
          end
        end
      end
    end
    lat_code = 2'b00;
    set_bank(8'h2B);

    // R7: 32-bit wrap
    run_read(8'h13, 32'hFFFF_FFFF, 2, "R7 address wrap");

    // R8: busy blocks reads
    busy = 1'b1;
    select(); send_byte(8'h03); send_byte(8'h00); send_byte(8'h00); send_byte(8'h04);
    read_byte(v, oe_all, oe_any); read_byte(v, oe_all, oe_any);
    check(!oe_any, "R8 busy 03h so_oe", {31'h0, oe_any}, 32'h0);
    deselect();
    select(); send_byte(8'h0C); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h07);
    for (int b = 0; b < 3; b++) begin read_byte(v, oe_all, oe_any); end
    check(!oe_any, "R8 busy 0Ch so_oe", {31'h0, oe_any}, 32'h0);
    deselect();
    busy = 1'b0;
    run_read(8'h03, 32'h0000_0009, 1, "R8 read after busy");

    // R9: aborted command, then fresh opcode
    select(); send_byte(8'h0C); send_byte(8'h12); send_byte(8'h34); deselect();
    run_read(8'h13, 32'h2000_0003, 2, "R9 after abort");

    // R9: unknown opcode ignored, bank untouched
    select(); send_byte(8'h9F); send_byte(8'hFF);
    read_byte(v, oe_all, oe_any);
    check(!oe_any, "R9 unknown opcode so_oe", {31'h0, oe_any}, 32'h0);
    deselect();
    run_read(8'h03, 32'h0000_000C, 2, "R9 bank kept after unknown opcode");

    // R10: load refused while selected
    select();
    check(ld_ready == 1'b0, "R10 ld_ready while selected", {31'h0, ld_ready}, 32'h0);
    ld_valid = 1'b1; ld_idx = 6'd5; ld_data = ~pat(5);
    tick(3);
    ld_valid = 1'b0;
    deselect();
    run_read(8'h13, 32'h0000_0005, 1, "R10 refused load");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule